// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Memory Guard

This block sits between a requester and a storage array that is 72 bits wide. A write takes a 64-bit data word, derives eight check bits from it with an extended Hamming code, and sends data and check bits to the array in the same cycle. A read fetches the stored word and recomputes the check bits from the stored data. The difference between the recomputed and stored check bits is the syndrome. Together with the overall parity of the stored word, the syndrome classifies the read as clean, as a single flip that can be corrected, or as uncorrectable.

A corrected read returns repaired data to the requester. The array itself is never rewritten, so a stored flip stays in place until the location is written again. An uncorrectable read raises a one-cycle flag, and the data comes back as it was stored. Every corrected read advances a saturating counter that the host can read. An alert output compares that counter with a threshold supplied by the host, and a clear input zeroes the counter.

The array answers reads combinationally from `mem_addr`, and the block registers its result. Read data and both flags therefore appear one cycle after the request.

Top module: `secded_mem_guard`

## Requirements
- R1: A write drives `mem_we` together with `mem_wdata`, where data sits in bits [63:0] and check bits sit in [71:64]. Reading back an unmodified word returns the written data with both error flags low.
- R2: `rd_valid`, `rd_data`, `err_corr` and `err_uncorr` are registered and appear in the cycle after `rd_en`. `rd_valid` is low after any cycle without `rd_en`, and neither flag is ever high without `rd_valid`.
- R3: A single flipped bit anywhere in stored data bits [63:0] is inverted back on `rd_data`, with `err_corr` high and `err_uncorr` low.
- R4: A single flipped bit among the stored check bits [71:64], including the overall parity bit 71, gives `err_corr` high with `rd_data` equal to the stored data.
- R5: Correction affects only the output. The stored word is not rewritten, so a second read of the same location again reports a corrected error.
- R6: Two flipped bits in one stored word give `err_uncorr` high and `err_corr` low, and `rd_data` returns the stored data uncorrected.
- R7: `ce_count` rises by exactly one for each corrected read, in the same cycle as the `err_corr` result. Clean and uncorrectable reads leave it unchanged.
- R8: `ce_count` saturates at 2^CNT_W-1 instead of wrapping.
- R9: `ce_alert` is high exactly when `ce_count` is greater than or equal to `ce_thresh`.
- R10: `ce_clear` sets `ce_count` to zero on the next clock edge, overriding any increment in that cycle. `ce_alert` then drops for any nonzero threshold.
- R11: After reset, `rd_valid`, both flags and `ce_count` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| addr | input | ADDR_W | Word address for the request |
| wr_data | input | 64 | Data to store |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 64 | Corrected read data |
| err_corr | output | 1 | Read had a corrected single-bit error |
| err_uncorr | output | 1 | Read had an uncorrectable error (pulse) |
| ce_thresh | input | CNT_W | Alert threshold for the corrected count |
| ce_clear | input | 1 | Zero the corrected-error counter |
| ce_count | output | CNT_W | Saturating corrected-error count |
| ce_alert | output | 1 | Count has reached the threshold |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array address |
| mem_wdata | output | 72 | Codeword to store |
| mem_rdata | input | 72 | Codeword read from the array, valid in the same cycle as `mem_addr` |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle. They also assume that the array returns, in the same cycle, whatever was last written or corrupted at `mem_addr`. The bench drives each request in its own cycle and changes array contents only through a separate fault-injection path between requests. It flips at most two bits per word, because three or more flips lie outside what the code can classify. The counter assertions take `ce_clear` as the only event that may lower the count, and the bench changes the threshold only while no read is in flight.

// File: rtl/secded_pkg.sv
// Package: code geometry and syndrome helpers for a 64+8 extended Hamming code.
// Assumes data bits occupy the non-power-of-two Hamming positions 3..71 in order.
package secded_pkg;
    localparam int DATA_W = 64;
    localparam int HCHK_W = 7;
    localparam int CODE_W = DATA_W + HCHK_W + 1;

    // Hamming position of data bit idx: the idx-th position >= 3 that is not a power of two
    function automatic int unsigned pos_of(int unsigned idx);
        int unsigned cnt;
        int unsigned res;
        cnt = 0;
        res = 0;
        for (int unsigned p = 3; p < 128; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == idx && res == 0) res = p;
                cnt++;
            end
        end
        return res;
    endfunction

    // XOR of the positions of all set data bits
    function automatic logic [HCHK_W-1:0] hsyn(logic [DATA_W-1:0] d);
        logic [HCHK_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < DATA_W; i++)
            if (d[i]) acc ^= HCHK_W'(pos_of(i));
        return acc;
    endfunction
endpackage

// File: rtl/secded_encoder.sv
// Module: derives the eight check bits for one data word.
// Bits [6:0] are the Hamming bits; bit 7 makes the parity of all 72 bits even.
module secded_encoder
    import secded_pkg::*;
(
    input  logic [DATA_W-1:0]   data_i,
    output logic [HCHK_W:0]     check_o
);
    logic [HCHK_W-1:0] h;

    // Hamming bits plus overall parity
    always_comb begin
        h       = hsyn(data_i);
        check_o = {(^data_i) ^ (^h), h};
    end
endmodule

// File: rtl/secded_decoder.sv
// Module: classifies a stored codeword and repairs a single data-bit flip.
// Purely combinational. Assumes the {check, data} layout written by secded_encoder.
module secded_decoder
    import secded_pkg::*;
(
    input  logic [CODE_W-1:0]   word_i,
    output logic [DATA_W-1:0]   data_o,
    output logic                corr_o,
    output logic                uncorr_o
);
    logic [DATA_W-1:0] d;
    logic [HCHK_W-1:0] syn;
    logic              odd;
    logic              syn_chk;
    logic [DATA_W-1:0] flip;

    // Syndrome and overall parity
    always_comb begin
        d       = word_i[DATA_W-1:0];
        syn     = hsyn(d) ^ word_i[DATA_W+HCHK_W-1:DATA_W];
        odd     = ^word_i;
        syn_chk = (syn & (syn - 1'b1)) == '0;
    end

    // One comparator per data bit against its fixed position
    for (genvar i = 0; i < DATA_W; i++) begin : g_flip
        localparam logic [HCHK_W-1:0] POS = HCHK_W'(pos_of(i));
        assign flip[i] = (syn == POS);
    end

    // Classification and repair
    always_comb begin
        corr_o   = odd && (syn_chk || (|flip));
        uncorr_o = (!odd && syn != '0) || (odd && !syn_chk && !(|flip));
        data_o   = corr_o ? (d ^ flip) : d;
    end
endmodule

// File: rtl/secded_ce_counter.sv
// Module: saturating corrected-error counter with threshold alert.
// Assumes inc is a one-cycle pulse per corrected read. clr has priority over inc.
module secded_ce_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    input  logic [CNT_W-1:0] thresh,
    output logic [CNT_W-1:0] count,
    output logic             alert
);
    localparam logic [CNT_W-1:0] MAX = '1;

    // Count update: clear, else saturating increment
    always_ff @(posedge clk) begin
        if (!rst_n)            count <= '0;
        else if (clr)          count <= '0;
        else if (inc && count != MAX) count <= count + 1'b1;
    end

    // Threshold comparison
    assign alert = (count >= thresh);

    // R10
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);
    // R8
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == MAX && !clr) |=> count == MAX);
    // R7
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && count != MAX) |=> count == $past(count) + 1'b1);
    // R7
    no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(count));
endmodule

// File: rtl/secded_mem_guard.sv
// Module: top of the memory guard. Encodes on write, decodes and registers reads,
// and counts corrected errors. Assumes an array that answers mem_addr in the same cycle
// and that wr_en and rd_en are never high in the same cycle.
module secded_mem_guard
    import secded_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [63:0]        wr_data,
    output logic               rd_valid,
    output logic [63:0]        rd_data,
    output logic               err_corr,
    output logic               err_uncorr,
    input  logic [CNT_W-1:0]   ce_thresh,
    input  logic               ce_clear,
    output logic [CNT_W-1:0]   ce_count,
    output logic               ce_alert,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [71:0]        mem_wdata,
    input  logic [71:0]        mem_rdata
);
    logic [HCHK_W:0]   chk;
    logic [DATA_W-1:0] dec_data;
    logic              dec_corr;
    logic              dec_uncorr;

    secded_encoder u_enc (.data_i(wr_data), .check_o(chk));

    secded_decoder u_dec (
        .word_i  (mem_rdata),
        .data_o  (dec_data),
        .corr_o  (dec_corr),
        .uncorr_o(dec_uncorr)
    );

    secded_ce_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (rd_en && dec_corr),
        .clr   (ce_clear),
        .thresh(ce_thresh),
        .count (ce_count),
        .alert (ce_alert)
    );

    // Array side: write strobe, shared address, codeword
    assign mem_we    = wr_en;
    assign mem_addr  = addr;
    assign mem_wdata = {chk, wr_data};

    // Registered read result stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid   <= 1'b0;
            rd_data    <= '0;
            err_corr   <= 1'b0;
            err_uncorr <= 1'b0;
        end else begin
            rd_valid   <= rd_en;
            err_corr   <= rd_en && dec_corr;
            err_uncorr <= rd_en && dec_uncorr;
            if (rd_en) rd_data <= dec_data;
        end
    end

    // R2
    rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    // R2
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
    // R6
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_corr, err_uncorr}));
    // R2
    flag_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_corr || err_uncorr) |-> rd_valid);
    // R7
    corr_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_uncorr && !$past(ce_clear)) |-> ce_count == $past(ce_count));
endmodule

// File: tb/secded_mem_guard_bench.sv
module secded_mem_guard_bench;
    localparam int AW = 4;
    localparam int CW = 4;

    typedef struct {
        logic [63:0] d;
        logic        c;
        logic        u;
        string       req;
    } exp_t;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          wr_en = 0, rd_en = 0, ce_clear = 0;
    logic [AW-1:0] addr = '0;
    logic [63:0]   wr_data = '0;
    logic [CW-1:0] ce_thresh = 4'd3;
    logic          rd_valid, err_corr, err_uncorr, ce_alert, mem_we;
    logic [63:0]   rd_data;
    logic [CW-1:0] ce_count;
    logic [AW-1:0] mem_addr;
    logic [71:0]   mem_wdata, mem_rdata;
    logic [71:0]   ram [16];
    logic          inj_en = 0;
    logic [AW-1:0] inj_addr = '0;
    logic [71:0]   inj_mask = '0;

    int   n_chk = 0, n_err = 0;
    bit   done = 0;
    exp_t q[$];
    logic [63:0] model [16];

    always #4 clk = ~clk;

    secded_mem_guard #(.ADDR_W(AW), .CNT_W(CW)) u_secded_mem_guard (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data),
        .err_corr(err_corr), .err_uncorr(err_uncorr), .ce_thresh(ce_thresh),
        .ce_clear(ce_clear), .ce_count(ce_count), .ce_alert(ce_alert),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // Behavioural array with a fault-injection port
    assign mem_rdata = ram[mem_addr];
    always @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= mem_wdata;
        else if (inj_en) ram[inj_addr] <= ram[inj_addr] ^ inj_mask;
    end

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pop expected read results and compare
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (q.size() == 0) check("R2 unexpected rd_valid", 64'd1, 64'd0);
            else begin
                exp_t e;
                e = q.pop_front();
                check({e.req, " data"}, rd_data, e.d);
                check({e.req, " err_corr"}, {63'd0, err_corr}, {63'd0, e.c});
                check({e.req, " err_uncorr"}, {63'd0, err_uncorr}, {63'd0, e.u});
            end
        end
    end

    task automatic do_write(int a, logic [63:0] d);
        @(negedge clk);
        wr_en = 1; addr = AW'(a); wr_data = d; model[a] = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic do_read(int a, logic [63:0] d, logic c, logic u, string req);
        exp_t e;
        e.d = d; e.c = c; e.u = u; e.req = req;
        @(negedge clk);
        rd_en = 1; addr = AW'(a);
        q.push_back(e);
        @(negedge clk);
        rd_en = 0;
    endtask

    task automatic inject(int a, logic [71:0] m);
        @(negedge clk);
        inj_en = 1; inj_addr = AW'(a); inj_mask = m;
        @(negedge clk);
        inj_en = 0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [71:0] m2;
        for (int i = 0; i < 16; i++) ram[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        check("R11 rd_valid", {63'd0, rd_valid}, 64'd0);
        check("R11 flags", {62'd0, err_corr, err_uncorr}, 64'd0);
        check("R11 ce_count", {60'd0, ce_count}, 64'd0);
        check("R9 alert below thresh", {63'd0, ce_alert}, 64'd0);

        // R1 clean write and read
        do_write(0, 64'h0123_4567_89AB_CDEF);
        do_write(1, 64'hFFFF_FFFF_FFFF_FFFF);
        do_write(2, 64'h0);
        do_write(3, 64'hA5A5_5A5A_0F0F_F0F0);
        for (int i = 0; i < 4; i++) do_read(i, model[i], 0, 0, "R1 clean read");
        @(negedge clk);
        check("R2 idle no valid", {63'd0, rd_valid}, 64'd0);
        check("R7 clean no count", {60'd0, ce_count}, 64'd0);

        // R3 data flip corrected
        inject(0, 72'd1 << 5);
        do_read(0, model[0], 1, 0, "R3 data bit 5");
        check("R7 count 1", {60'd0, ce_count}, 64'd1);
        // R5 array untouched, second read corrects again
        do_read(0, model[0], 1, 0, "R5 reread");
        check("R7 count 2", {60'd0, ce_count}, 64'd2);
        check("R9 alert at 2", {63'd0, ce_alert}, 64'd0);
        // R4 check-bit flips
        inject(1, 72'd1 << 66);
        do_read(1, model[1], 1, 0, "R4 check bit 66");
        check("R9 alert at 3", {63'd0, ce_alert}, 64'd1);
        inject(2, 72'd1 << 71);
        do_read(2, model[2], 1, 0, "R4 parity bit 71");
        check("R7 count 4", {60'd0, ce_count}, 64'd4);
        // R3 top data bit
        inject(1, (72'd1 << 66) | (72'd1 << 63));
        do_read(1, model[1], 1, 0, "R3 data bit 63");
        check("R7 count 5", {60'd0, ce_count}, 64'd5);
        // R6 double flip
        m2 = (72'd1 << 10) | (72'd1 << 40);
        inject(3, m2);
        do_read(3, model[3] ^ m2[63:0], 0, 1, "R6 double data");
        inject(2, 72'd1 << 0);
        do_read(2, 64'd1, 0, 1, "R6 data+parity");
        check("R7 uncorr no count", {60'd0, ce_count}, 64'd5);
        // R1 rewrite clears stored flip
        do_write(0, model[0]);
        do_read(0, model[0], 0, 0, "R1 rewritten");
        // R9 raised threshold
        ce_thresh = 4'd9;
        @(negedge clk);
        check("R9 alert below 9", {63'd0, ce_alert}, 64'd0);
        ce_thresh = 4'd3;
        // R10 clear
        @(negedge clk); ce_clear = 1;
        @(negedge clk); ce_clear = 0;
        check("R10 cleared", {60'd0, ce_count}, 64'd0);
        check("R10 alert low", {63'd0, ce_alert}, 64'd0);
        // R8 saturation
        inject(0, 72'd1 << 0);
        for (int k = 0; k < 18; k++) do_read(0, model[0], 1, 0, "R8 sat read");
        check("R8 saturated", {60'd0, ce_count}, 64'd15);
        check("R9 alert saturated", {63'd0, ce_alert}, 64'd1);
        repeat (2) @(negedge clk);
        check("R2 queue drained", 64'(q.size()), 64'd0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule